// File: doc/BRIEF.md
# Chainable Byte Timer with Edge Capture

This block is a general-purpose timer made from two 8-bit counting lanes. The lanes run alone or chain into one 16-bit counter. The count advances on a tick. A tick comes either from the system clock divided by a power of two, or from rising edges on an external count pin. A comparator checks the count against a programmable match value. When they are equal, the comparator clears the count, sets a timer interrupt flag and can toggle a compare-output pin. The toggling pin gives a square wave with a 50% duty cycle.

A selected edge on an external event pin sets a second interrupt flag. When capture is on, the same edge copies the running count into a capture register. Software drives the block through a byte-wide register port. Writes take effect at the clock edge that samples them. Reads return data one cycle after the request. Both flags are sticky and are cleared by writing ones.

Register addresses: 0 control A, 1 control B, 2 match low byte, 3 match high byte, 4 capture low byte, 5 capture high byte, 6 flags, 7 count low byte, 8 count high byte.

Top module: `dbt_timer`

## Requirements
- R1: After reset, every register reads 0, the count is 0, and `cmp_out`, `tmr_irq` and `ext_irq` are low.
- R2: In control A, bits [2:0] select the tick source and bit 3 is the run bit. Codes 1 to 7 divide the system clock by 2, 4, 8, 32, 128, 512 and 1024. The prescaler restarts at a start write, so k cycles after that write the count equals floor(k/N), reduced by any match wraparound.
- R3: Tick code 0 counts rising edges of `ext_clk_pin`. The pin passes through a two-flop synchronizer first, and each low-to-high transition adds exactly one.
- R4: A write to control A with bit 3 set clears the count and the prescaler, then counting starts. A write with bit 3 clear stops counting, and the count holds its value.
- R5: Control B bit 0 selects 16-bit mode. When it is 0, only the low lane counts, wrapping from 255 to 0. The high count byte then reads 0, and only the low match byte is compared.
- R6: On a tick where the count equals the match value, the count returns to 0 instead of incrementing, and the timer flag (flags bit 0, `tmr_irq`) is set.
- R7: Control B bits [4:3] select the event edge: 00 falling, 01 rising, 10 both, 11 none. A selected edge on `ext_int_pin` sets the event flag (flags bit 1, `ext_irq`). When control A bit 4 is set, the edge also loads the capture register with the count as it stood two cycles after the pin change.
- R8: `cmp_out` toggles on every match tick only while control B bit 2 (output enable) is 1 and bit 1 (modulation enable) is 0. Otherwise it is held at 0.
- R9: Writing 1 to a bit of the flags register clears that flag. Writing 0 leaves it unchanged.
- R10: The control and match registers read back as written. Read data is registered and appears on the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ext_clk_pin | input | 1 | External count input |
| ext_int_pin | input | 1 | External event input for capture |
| cmp_out | output | 1 | Compare toggle output |
| tmr_irq | output | 1 | Sticky match flag |
| ext_irq | output | 1 | Sticky event flag |

## Verification
The assertions assume that both external pins are asynchronous but change no faster than the synchronizer can follow. They also assume the tick code is not rewritten in the same cycle as a divided tick. The stimulus holds each external pin level for at least three clock cycles. It changes the tick code only with the counter stopped, so every edge is seen once and the prescaler phase is known from the start write. Expected counts, captures and toggle levels come from the elapsed cycle number since the start write, using floor division and modular reduction.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int CNT_W  = BYTE_W * LANES;

  localparam int RA_CFG_A   = 0;
  localparam int RA_CFG_B   = 1;
  localparam int RA_MATCH_L = 2;
  localparam int RA_MATCH_H = 3;
  localparam int RA_CAP_L   = 4;
  localparam int RA_CAP_H   = 5;
  localparam int RA_FLAGS   = 6;
  localparam int RA_CNT_L   = 7;
  localparam int RA_CNT_H   = 8;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_sel_e;

  // log2 of the divide ratio for each tick code; 0 means external source
  function automatic int unsigned div_shift(input logic [2:0] code);
    case (code)
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return 3;
      3'd4:    return 5;
      3'd5:    return 7;
      3'd6:    return 9;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/dbt_pin_sync.sv
module dbt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= pin;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= 1'b0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R3
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall); // R7
endmodule

// File: rtl/dbt_prescaler.sv
module dbt_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [2:0] sel,
  input  logic       ext_rise,
  output logic       tick
);
  logic [PRE_W-1:0] acc;
  logic [PRE_W-1:0] mask;
  int unsigned      sh;

  always_comb begin
    sh = dbt_pkg::div_shift(sel);
    for (int b = 0; b < PRE_W; b++) mask[b] = (b < sh);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else            acc <= acc + PRE_W'(1);
  end

  assign tick = (sel == 3'd0) ? ext_rise : ((acc & mask) == mask);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (sel != 3'd0 && tick && !clr) |=> (!tick || sel != $past(sel))); // R2
endmodule

// File: rtl/dbt_count_core.sv
module dbt_count_core #(
  parameter int BW    = 8,
  parameter int LANES = 2,
  localparam int W    = BW * LANES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         run,
  input  logic         tick,
  input  logic         wide,
  input  logic [W-1:0] match,
  input  logic         cap_evt,
  input  logic         cap_en,
  input  logic         cmp_active,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cap,
  output logic         hit_evt,
  output logic         cmp_q
);
  logic hit;

  assign hit = wide ? (cnt == match) : (cnt[BW-1:0] == match[BW-1:0]);
  assign hit_evt = run && tick && hit && !start;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BW-1:0] lane_r;
    logic          carry_in;
    logic          lane_on;

    if (g == 0) begin : g_first
      assign carry_in = 1'b1;
      assign lane_on  = 1'b1;
    end else begin : g_rest
      assign carry_in = &cnt[g*BW-1:0];
      assign lane_on  = wide;
    end

    always_ff @(posedge clk) begin
      if (rst || start)        lane_r <= '0;
      else if (!lane_on)       lane_r <= '0;
      else if (run && tick) begin
        if (hit)               lane_r <= '0;
        else if (carry_in)     lane_r <= lane_r + BW'(1);
      end
    end

    assign cnt[g*BW +: BW] = lane_r;
  end

  always_ff @(posedge clk) begin
    if (rst)                  cap <= '0;
    else if (cap_evt && cap_en) cap <= cnt;
  end

  always_ff @(posedge clk) begin
    if (rst || !cmp_active) cmp_q <= 1'b0;
    else if (hit_evt)       cmp_q <= ~cmp_q;
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> cnt == '0); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run && !start && wide) |=> $stable(cnt)); // R4
  AST_STEP_WIDE: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !hit && !start && wide) |=> cnt == $past(cnt) + W'(1)); // R2
  AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (rst)
    hit_evt |=> cnt == '0); // R6
  AST_NARROW_HI: assert property (@(posedge clk) disable iff (rst)
    !wide |=> cnt[W-1:BW] == '0); // R5
  AST_CMP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cmp_active |=> !cmp_q); // R8
endmodule

// File: rtl/dbt_timer.sv
module dbt_timer #(
  parameter int ADDR_W      = 4,
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              ext_clk_pin,
  input  logic              ext_int_pin,
  output logic              cmp_out,
  output logic              tmr_irq,
  output logic              ext_irq
);
  import dbt_pkg::*;
  localparam int BW = BYTE_W;
  localparam int W  = CNT_W;

  logic [BW-1:0] cfg_a, cfg_b;
  logic [W-1:0]  match_q, cnt, cap;
  logic          tmr_flag, ext_flag;
  logic          start, tick, hit_evt, cap_evt;
  logic          clk_rise, clk_fall_unused, int_rise, int_fall;
  logic          cmp_active;
  edge_sel_e     edge_sel;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int r);
    return a == ADDR_W'(r);
  endfunction

  assign start      = wr_en && at(addr, RA_CFG_A) && wr_data[3];
  assign edge_sel   = edge_sel_e'(cfg_b[4:3]);
  assign cmp_active = cfg_b[2] && !cfg_b[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a   <= '0;
      cfg_b   <= '0;
      match_q <= '0;
    end else if (wr_en) begin
      if (at(addr, RA_CFG_A))   cfg_a <= wr_data;
      if (at(addr, RA_CFG_B))   cfg_b <= wr_data;
      if (at(addr, RA_MATCH_L)) match_q[BW-1:0] <= wr_data;
      if (at(addr, RA_MATCH_H)) match_q[W-1:BW] <= wr_data;
    end
  end

  dbt_pin_sync #(.STAGES(SYNC_STAGES)) i_clk_sync (
    .clk(clk), .rst(rst), .pin(ext_clk_pin),
    .rise(clk_rise), .fall(clk_fall_unused)
  );

  dbt_pin_sync #(.STAGES(SYNC_STAGES)) i_int_sync (
    .clk(clk), .rst(rst), .pin(ext_int_pin),
    .rise(int_rise), .fall(int_fall)
  );

  always_comb begin
    case (edge_sel)
      EDGE_FALL: cap_evt = int_fall;
      EDGE_RISE: cap_evt = int_rise;
      EDGE_BOTH: cap_evt = int_rise | int_fall;
      default:   cap_evt = 1'b0;
    endcase
  end

  dbt_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk(clk), .rst(rst), .clr(start), .sel(cfg_a[2:0]),
    .ext_rise(clk_rise), .tick(tick)
  );

  dbt_count_core #(.BW(BW), .LANES(LANES)) i_core (
    .clk(clk), .rst(rst), .start(start), .run(cfg_a[3]), .tick(tick),
    .wide(cfg_b[0]), .match(match_q), .cap_evt(cap_evt), .cap_en(cfg_a[4]),
    .cmp_active(cmp_active), .cnt(cnt), .cap(cap), .hit_evt(hit_evt),
    .cmp_q(cmp_out)
  );

  // sticky flags: an event in the same cycle wins over a clearing write
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_flag <= 1'b0;
      ext_flag <= 1'b0;
    end else begin
      if (hit_evt)                                      tmr_flag <= 1'b1;
      else if (wr_en && at(addr, RA_FLAGS) && wr_data[0]) tmr_flag <= 1'b0;
      if (cap_evt)                                      ext_flag <= 1'b1;
      else if (wr_en && at(addr, RA_FLAGS) && wr_data[1]) ext_flag <= 1'b0;
    end
  end

  assign tmr_irq = tmr_flag;
  assign ext_irq = ext_flag;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      if      (at(addr, RA_CFG_A))   rd_data <= cfg_a;
      else if (at(addr, RA_CFG_B))   rd_data <= cfg_b;
      else if (at(addr, RA_MATCH_L)) rd_data <= match_q[BW-1:0];
      else if (at(addr, RA_MATCH_H)) rd_data <= match_q[W-1:BW];
      else if (at(addr, RA_CAP_L))   rd_data <= cap[BW-1:0];
      else if (at(addr, RA_CAP_H))   rd_data <= cap[W-1:BW];
      else if (at(addr, RA_FLAGS))   rd_data <= {6'd0, ext_flag, tmr_flag};
      else if (at(addr, RA_CNT_L))   rd_data <= cnt[BW-1:0];
      else if (at(addr, RA_CNT_H))   rd_data <= cnt[W-1:BW];
      else                           rd_data <= '0;
    end
  end

  AST_TFLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tmr_flag && !(wr_en && at(addr, RA_FLAGS) && wr_data[0])) |=> tmr_flag); // R9
  AST_EFLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ext_flag && !(wr_en && at(addr, RA_FLAGS) && wr_data[1])) |=> ext_flag); // R9
  AST_EDGE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (edge_sel == EDGE_OFF && !ext_flag) |=> !ext_flag); // R7
  AST_CAP_HELD: assert property (@(posedge clk) disable iff (rst)
    !cfg_a[4] |=> $stable(cap)); // R7
endmodule

// File: tb/test_dbt_timer.sv
module test_dbt_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       ext_clk_pin = 1'b0, ext_int_pin = 1'b0;
  logic       cmp_out, tmr_irq, ext_irq;

  int vectors = 0, fails = 0;
  int edge_no = 0;
  int last_wr = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) edge_no <= edge_no + 1;

  dbt_timer i_dbt_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ext_clk_pin(ext_clk_pin),
    .ext_int_pin(ext_int_pin), .cmp_out(cmp_out), .tmr_irq(tmr_irq),
    .ext_irq(ext_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    last_wr = edge_no;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rd_data);
  endtask

  task automatic rd16(input int a, output int d);
    int lo, hi;
    rd(a, lo);
    rd(a + 1, hi);
    d = (hi << 8) | lo;
  endtask

  function automatic int div_of(input int sel);
    case (sel)
      1: return 2;    2: return 4;   3: return 8;   4: return 32;
      5: return 128;  6: return 512; 7: return 1024;
      default: return 1;
    endcase
  endfunction

  // run a counting session and check the frozen count and the match flag
  task automatic count_case(input int sel, input int wide, input int m, input int k, input string req);
    int n, t, modv, t0, es, got;
    n = div_of(sel);
    wr(1, wide);
    wr(2, m & 255);
    wr(3, (m >> 8) & 255);
    wr(6, 3);
    wr(0, sel | 8);
    t0 = last_wr;
    repeat (k) @(negedge clk);
    wr(0, sel);
    es = last_wr;
    t = (es - t0) / n;
    modv = wide ? (m + 1) : ((m & 255) + 1);
    rd16(7, got);
    check(req, got, t % modv);
    check("R6 flag", int'(tmr_irq), (t >= modv) ? 1 : 0);
  endtask

  initial begin
    int v, t0, er, ef, n, vr, vf, prev_cap, expc;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a <= 8; a++) begin
      rd(a, v);
      check("R1 reg", v, 0);
    end
    check("R1 cmp_out", int'(cmp_out), 0);
    check("R1 irq", int'(tmr_irq) | int'(ext_irq), 0);

    // R10 readback
    wr(2, 8'hA5); wr(3, 8'h3C); wr(1, 8'h1A);
    rd(2, v); check("R10 match lo", v, 8'hA5);
    rd(3, v); check("R10 match hi", v, 8'h3C);
    rd(1, v); check("R10 cfg b", v, 8'h1A);

    // R2 / R6 sweep over tick codes, match values and both widths
    for (int sel = 1; sel <= 7; sel++)
      for (int mi = 0; mi < 3; mi++) begin
        int mv;
        mv = (mi == 0) ? 0 : (mi == 1) ? 3 : 16'h0206;
        count_case(sel, sel & 1, mv, div_of(sel) * (12 + mi) + div_of(sel) / 2, "R2 count");
      end

    // R5 narrow wrap and wide carry
    count_case(1, 0, 16'h12FF, 600, "R5 narrow");
    count_case(1, 1, 16'h01FF, 600, "R5 wide");
    count_case(1, 1, 16'h0120, 600, "R6 wide wrap");

    // R4 hold after stop, then restart clears
    rd16(7, v);
    repeat (20) @(negedge clk);
    rd16(7, expc);
    check("R4 hold", expc, v);
    wr(0, 8'h09);
    rd(7, v);
    check("R4 restart clears", v, 0);
    wr(0, 8'h01);

    // R9 write-one-to-clear (flag is set from the previous cases)
    check("R9 pre", int'(tmr_irq), 1);
    wr(6, 2);
    check("R9 other bit", int'(tmr_irq), 1);
    wr(6, 1);
    check("R9 cleared", int'(tmr_irq), 0);

    // R3 external count source
    wr(1, 1); wr(2, 8'hFF); wr(3, 8'hFF);
    wr(0, 8'h08);
    for (int p = 0; p < 5; p++) begin
      ext_clk_pin = 1'b1; repeat (3) @(negedge clk);
      ext_clk_pin = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    wr(0, 8'h00);
    rd16(7, v);
    check("R3 ext pulses", v, 5);

    // R7 capture on each edge selection
    prev_cap = 0;
    for (int mode = 0; mode < 4; mode++) begin
      n = div_of(mode + 1);
      wr(1, 1 | (mode << 3));
      wr(6, 3);
      wr(0, (mode + 1) | 8 | 16);
      t0 = last_wr;
      repeat (9) @(negedge clk);
      er = edge_no; ext_int_pin = 1'b1;
      repeat (7) @(negedge clk);
      ef = edge_no; ext_int_pin = 1'b0;
      repeat (6) @(negedge clk);
      vr = (er + 2 - t0) / n;
      vf = (ef + 2 - t0) / n;
      expc = (mode == 0) ? vf : (mode == 1) ? vr : (mode == 2) ? vf : prev_cap;
      rd16(4, v);
      check("R7 capture", v, expc);
      check("R7 event flag", int'(ext_irq), (mode == 3) ? 0 : 1);
      prev_cap = expc;
      wr(0, mode + 1);
    end
    // R7 capture disabled: flag sets, register keeps its value
    wr(1, 1 | (1 << 3));
    wr(6, 3);
    wr(0, 1 | 8);
    repeat (5) @(negedge clk);
    ext_int_pin = 1'b1; repeat (6) @(negedge clk);
    ext_int_pin = 1'b0; repeat (4) @(negedge clk);
    rd16(4, v);
    check("R7 cap off keeps", v, prev_cap);
    check("R7 cap off flag", int'(ext_irq), 1);
    wr(0, 1);

    // R8 compare toggle, narrow, div 2, match 2
    wr(1, 8'h04); wr(2, 2); wr(3, 0);
    wr(0, 1 | 8);
    t0 = last_wr;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check("R8 toggle", int'(cmp_out), (((edge_no - t0) / 2) / 3) & 1);
    end
    wr(1, 8'h06);
    wr(0, 1 | 8);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R8 modulation blocks", int'(cmp_out), 0);
    end
    wr(0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule